// File: doc/BRIEF.md
# Significand Alignment Right Shifter

This combinational block moves a 24-bit significand (the hidden leading 1 included) toward the least significant end by a count taken from an 8-bit exponent difference. It runs ahead of the adder in a floating-point addition path: the smaller operand's significand enters on `sig_in`, the exponent difference enters on `shamt`, and the aligned value leaves on `sig_out` in the same cycle. Positions vacated at the top are filled with zeros.

The shift is split into two cascaded stages. A coarse stage moves the value by a whole multiple of eight positions, chosen by count bits 4 and 3. A fine stage then moves it by 0 to 7 positions, chosen by count bits 2 to 0. The upper three count bits feed a gate. When any of them is set, the shift is at least 32 and the gate forces the coarse stage output to zero. Counts from 24 to 31 need no special case because a coarse move of 24 already clears every bit. A parameter selects whether the fine stage is a flat eight-way selector per bit or three binary layers.

Top module: `align_rshift`

## Requirements
- R1: For every count from 0 to 23, `sig_out` equals `sig_in` shifted right by `shamt` positions.
- R2: For every count of 24 or more, `sig_out` is all zeros for any `sig_in`.
- R3: When any of `shamt` bits 7, 6 or 5 is 1, `sig_out` is all zeros whatever the values of `shamt` bits 4 to 0 and of `sig_in`.
- R4: A count of 0 passes `sig_in` to `sig_out` unchanged.
- R5: For every count below 24, bit 0 of `sig_out` equals bit `shamt` of `sig_in`, so every input bit can reach the least significant output position.
- R6: The top `shamt` bit positions of `sig_out` are always 0 (the zero fill).
- R7: The output depends only on the present inputs: a change on `sig_in` or `shamt` appears on `sig_out` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sig_in | input | 24 | Significand to align, hidden bit included |
| shamt | input | 8 | Unsigned right-shift count (exponent difference) |
| sig_out | output | 24 | Aligned significand |

## Verification
The assertions assume that both inputs carry known values and have settled before they are evaluated. They also assume that `shamt` is read as an unsigned count, so every value from 0 to 255 is legal. The bench drives only whole defined vectors and samples a fixed delay after each change. It sweeps all 256 counts across several fixed and random significands, so every input combination the assertions reason about is valid.

// File: rtl/align_rshift_pkg.sv
package align_rshift_pkg;
   typedef enum int unsigned {
      FINE_FLAT = 0,
      FINE_LOG  = 1
   } fine_arch_e;
endpackage

// File: rtl/align_range_gate.sv
module align_range_gate #(
   parameter int CNT_W   = 8,
   parameter int LIVE_W  = 5,
   parameter int FINE_W  = 3
) (
   input  logic [CNT_W-1:0]         cnt,
   output logic                     live,
   output logic [LIVE_W-FINE_W-1:0] coarse_sel,
   output logic [FINE_W-1:0]        fine_sel
);
   localparam int HIGH_W = CNT_W - LIVE_W;

   generate
      if (HIGH_W < 1) begin : g_bad
         $error("align_range_gate: count width must exceed live width");
      end
   endgenerate

   assign live       = ~|cnt[CNT_W-1:LIVE_W];
   assign coarse_sel = cnt[LIVE_W-1:FINE_W];
   assign fine_sel   = cnt[FINE_W-1:0];

   always_comb begin
      // R3: a live count never has a high bit set
      a_r3_live_means_small: assert (!live || cnt < CNT_W'(1 << LIVE_W))
         else $error("a_r3_live_means_small");
   end
endmodule

// File: rtl/align_coarse_stage.sv
module align_coarse_stage #(
   parameter int W      = 24,
   parameter int STEP   = 8,
   parameter int SEL_W  = 2
) (
   input  logic [W-1:0]     din,
   input  logic             live,
   input  logic [SEL_W-1:0] sel,
   output logic [W-1:0]     dout
);
   localparam int TAPS = 1 << SEL_W;

   generate
      if (STEP < 1) begin : g_bad
         $error("align_coarse_stage: STEP must be positive");
      end
      for (genvar j = 0; j < W; j++) begin : g_bit
         logic [TAPS-1:0] hit;
         for (genvar k = 0; k < TAPS; k++) begin : g_tap
            if (j + k * STEP < W) begin : g_in
               assign hit[k] = (sel == SEL_W'(k)) & din[j + k * STEP];
            end else begin : g_out
               assign hit[k] = 1'b0;
            end
         end
         assign dout[j] = live & (|hit);
      end
   endgenerate

   always_comb begin
      // R3: gate closed clears the intermediate vector
      a_r3_gate_clears: assert (live || dout == '0)
         else $error("a_r3_gate_clears");
      // R6: coarse move leaves top STEP*sel positions empty
      a_r6_coarse_fill: assert (!live || (dout & ~({W{1'b1}} >> (STEP * int'(sel)))) == '0)
         else $error("a_r6_coarse_fill");
   end
endmodule

// File: rtl/align_fine_stage.sv
module align_fine_stage
   import align_rshift_pkg::*;
#(
   parameter int         W     = 24,
   parameter int         SEL_W = 3,
   parameter fine_arch_e ARCH  = FINE_LOG
) (
   input  logic [W-1:0]     din,
   input  logic [SEL_W-1:0] sel,
   output logic [W-1:0]     dout
);
   localparam int TAPS = 1 << SEL_W;

   generate
      if (TAPS > W) begin : g_bad
         $error("align_fine_stage: fine reach exceeds width");
      end
      if (ARCH == FINE_FLAT) begin : g_flat
         for (genvar j = 0; j < W; j++) begin : g_bit
            logic [TAPS-1:0] hit;
            for (genvar k = 0; k < TAPS; k++) begin : g_tap
               if (j + k < W) begin : g_in
                  assign hit[k] = (sel == SEL_W'(k)) & din[j + k];
               end else begin : g_out
                  assign hit[k] = 1'b0;
               end
            end
            assign dout[j] = |hit;
         end
      end else begin : g_log
         logic [W-1:0] layer [SEL_W+1];
         assign layer[0] = din;
         for (genvar l = 0; l < SEL_W; l++) begin : g_layer
            assign layer[l+1] = sel[l] ? (layer[l] >> (1 << l)) : layer[l];
         end
         assign dout = layer[SEL_W];
      end
   endgenerate

   always_comb begin
      // R1: the fine move never adds set bits
      a_r1_fine_popcount: assert ($countones(dout) <= $countones(din))
         else $error("a_r1_fine_popcount");
   end
endmodule

// File: rtl/align_rshift.sv
module align_rshift
   import align_rshift_pkg::*;
#(
   parameter int         SIG_W     = 24,
   parameter int         CNT_W     = 8,
   parameter int         STEP      = 8,
   parameter fine_arch_e FINE_ARCH = FINE_LOG
) (
   input  logic [SIG_W-1:0] sig_in,
   input  logic [CNT_W-1:0] shamt,
   output logic [SIG_W-1:0] sig_out
);
   localparam int LIVE_W   = $clog2(SIG_W);
   localparam int FINE_W   = $clog2(STEP);
   localparam int COARSE_W = LIVE_W - FINE_W;

   generate
      if (STEP != (1 << FINE_W)) begin : g_bad_step
         $error("align_rshift: STEP must be a power of two");
      end
      if (COARSE_W < 1) begin : g_bad_split
         $error("align_rshift: STEP too large for SIG_W");
      end
      if (CNT_W <= LIVE_W) begin : g_bad_cnt
         $error("align_rshift: CNT_W too small");
      end
   endgenerate

   logic                live;
   logic [COARSE_W-1:0] coarse_sel;
   logic [FINE_W-1:0]   fine_sel;
   logic [SIG_W-1:0]    mid;

   align_range_gate #(
      .CNT_W (CNT_W),
      .LIVE_W(LIVE_W),
      .FINE_W(FINE_W)
   ) u_gate (
      .cnt       (shamt),
      .live      (live),
      .coarse_sel(coarse_sel),
      .fine_sel  (fine_sel)
   );

   align_coarse_stage #(
      .W    (SIG_W),
      .STEP (STEP),
      .SEL_W(COARSE_W)
   ) u_coarse (
      .din (sig_in),
      .live(live),
      .sel (coarse_sel),
      .dout(mid)
   );

   align_fine_stage #(
      .W    (SIG_W),
      .SEL_W(FINE_W),
      .ARCH (FINE_ARCH)
   ) u_fine (
      .din (mid),
      .sel (fine_sel),
      .dout(sig_out)
   );

   always_comb begin
      // R2: counts at or past the width clear the output
      a_r2_wide_count_zero: assert (shamt < CNT_W'(SIG_W) || sig_out == '0)
         else $error("a_r2_wide_count_zero");
      // R4: zero count is identity
      a_r4_identity: assert (shamt != '0 || sig_out == sig_in)
         else $error("a_r4_identity");
      // R5: least significant output picks input bit number shamt
      a_r5_lsb_reach: assert (shamt >= CNT_W'(SIG_W) || sig_out[0] == sig_in[shamt[LIVE_W-1:0]])
         else $error("a_r5_lsb_reach");
      // R6: zero fill above the shifted value
      a_r6_top_fill: assert ((sig_out & ~({SIG_W{1'b1}} >> shamt)) == '0)
         else $error("a_r6_top_fill");
   end
endmodule

// File: tb/align_rshift_bench.sv
module align_rshift_bench;
   logic        clk = 1'b0;
   logic [23:0] sig_in;
   logic [7:0]  shamt;
   logic [23:0] sig_out;
   int          n_checks = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   align_rshift u_align_rshift (
      .sig_in (sig_in),
      .shamt  (shamt),
      .sig_out(sig_out)
   );

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s m=%h n=%0d actual=%h expected=%h", req, sig_in, shamt, act, exp);
      end
   endtask

   task automatic apply(input logic [23:0] m, input logic [7:0] n);
      sig_in = m;
      shamt  = n;
      #2;
   endtask

   task automatic t_start_state;
      apply(24'h000000, 8'd0);
      chk("R4 start", sig_out, 24'h000000);
   endtask

   task automatic t_identity;
      apply(24'hA5C3F1, 8'd0);
      chk("R4 identity", sig_out, 24'hA5C3F1);
      apply(24'hFFFFFF, 8'd0);
      chk("R4 identity ones", sig_out, 24'hFFFFFF);
   endtask

   task automatic t_full_sweep;
      logic [23:0] pats [5];
      pats[0] = 24'h800000;
      pats[1] = 24'hFFFFFF;
      pats[2] = 24'h9ABCDE;
      pats[3] = 24'($urandom) | 24'h800000;
      pats[4] = 24'($urandom) | 24'h800000;
      for (int p = 0; p < 5; p++) begin
         for (int n = 0; n < 256; n++) begin
            apply(pats[p], 8'(n));
            if (n < 24) chk("R1 sweep", sig_out, pats[p] >> n);
            else        chk("R2 sweep", sig_out, 24'h000000);
         end
      end
   endtask

   task automatic t_large_counts;
      for (int n = 24; n < 32; n++) begin
         apply(24'hFFFFFF, 8'(n));
         chk("R2 count 24..31", sig_out, 24'h000000);
      end
      for (int h = 1; h < 8; h++) begin
         for (int lo = 0; lo < 32; lo += 7) begin
            apply(24'hFFFFFF, 8'((h << 5) | lo));
            chk("R3 high bits set", sig_out, 24'h000000);
         end
      end
   endtask

   task automatic t_lsb_reach;
      for (int n = 0; n < 24; n++) begin
         apply(24'h000001 << n, 8'(n));
         chk("R5 lsb reach", sig_out, 24'h000001);
      end
   endtask

   task automatic t_fill;
      for (int n = 0; n < 24; n++) begin
         apply(24'hFFFFFF, 8'(n));
         chk("R6 zero fill", sig_out & ~(24'hFFFFFF >> n), 24'h000000);
      end
   endtask

   task automatic t_combinational;
      sig_in = 24'h123456;
      shamt  = 8'd4;
      #1;
      chk("R7 no clock", sig_out, 24'h012345);
      shamt = 8'd12;
      #1;
      chk("R7 count change", sig_out, 24'h000123);
      sig_in = 24'hF00000;
      #1;
      chk("R7 data change", sig_out, 24'h000F00);
   endtask

   initial begin
      sig_in = '0;
      shamt  = '0;
      #1;
      t_start_state();
      t_identity();
      t_full_sweep();
      t_large_counts();
      t_lsb_reach();
      t_fill();
      t_combinational();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
         $finish;
      end
   end
endmodule